// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Shadow Context Save

This block sits beside a processor core and decides which interrupt the core takes next. It watches four active-low user request lines and one active-low nonmaskable line. Each user line passes through a two-stage synchronizer, and a falling edge on it is latched into a flag register. The core can read that register and clear bits in it. A mask register enables each user line on its own. A global block bit stops every user request at once.

When an enabled request is pending, the controller raises a one-cycle acknowledge. With it, it presents a vector address equal to a base plus twice the interrupt number. In the same cycle it copies eleven core context registers into a one-deep shadow store. Taking a request sets the global block bit, so a user handler is not interrupted by another user request. A return strobe from the core produces a restore pulse, with the shadow copy on the context output, and clears the block bit.

The nonmaskable line ignores both the mask and the block bit and outranks every user line. If it arrives while a handler is running, it overwrites the single shadow level.

Top module: `intr_prio_ctl`

## Requirements
- R1: After reset, irq_ack and ctx_restore are 0, irq_vector is 0 (the entry address the core starts from), flag_out and mask_out are all zero, and blk_out is 1 (user requests blocked).
- R2: A user line is active low. A falling edge on irq_n[i] sets flag_out[i] a few cycles later, after the two-flop synchronizer. Bit 0 is INT1 and bit 3 is INT4. Holding a line low sets the flag only once.
- R3: A pending user flag is acknowledged only while its mask_out bit is 1 and blk_out is 0. Otherwise it stays set in flag_out and no acknowledge is given.
- R4: When several enabled user flags are pending, INT1 (bit 0) is served first and INT4 (bit 3) last.
- R5: A flag_clr_we write clears each flag bit whose flag_clr_data bit is 1. Bits written as 0 are left unchanged.
- R6: Serving a user request INTn (n = 1..4) gives a one-cycle irq_ack with irq_vector = VEC_BASE + 2*n, clears that flag bit and sets blk_out in the same cycle.
- R7: In the cycle irq_ack is high, ctx_out already shows the ctx_in value sampled at the edge that raised irq_ack. It holds that value until the next acknowledge.
- R8: One cycle after an irq_ret strobe, ctx_restore pulses for one cycle while ctx_out still shows the saved context, and blk_out is 0.
- R9: A falling edge on nmi_n is acknowledged whatever mask_out and blk_out are, ahead of any pending user flag. Its vector is VEC_BASE + 2*NMI_NUM (36 by default), and it also sets blk_out and saves context.
- R10: A second acknowledge before irq_ret overwrites the shadow copy, so ctx_out shows the context sampled at the second entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_n | input | N_USER | Active-low user request lines, bit 0 = INT1 |
| nmi_n | input | 1 | Active-low nonmaskable request line |
| mask_we | input | 1 | Load the mask register |
| mask_wdata | input | N_USER | New mask value, 1 = enabled |
| flag_clr_we | input | 1 | Apply a write-one-to-clear to the flag register |
| flag_clr_data | input | N_USER | Flag bits to clear |
| blk_set | input | 1 | Set the global block bit |
| blk_clr | input | 1 | Clear the global block bit |
| irq_ret | input | 1 | Return-from-interrupt strobe |
| ctx_in | input | CTX_REGS*CTX_W | Core context registers, flattened |
| irq_ack | output | 1 | One-cycle acknowledge of the served request |
| irq_vector | output | VEC_W | Vector address of the last served request |
| ctx_out | output | CTX_REGS*CTX_W | Shadow context copy |
| ctx_restore | output | 1 | One-cycle restore pulse after a return |
| flag_out | output | N_USER | Pending flag register |
| mask_out | output | N_USER | Mask register |
| blk_out | output | 1 | Global block bit |

## Verification
The bench drives two pending requests while the block bit is set. It expects both flags to stay set without an acknowledge, and after unblocking it expects INT2 before INT4. A wrong priority encoder would give the vectors in the reverse order, and a missing block check would acknowledge too early. A masked INT1 must stay pending, and a zero-valued clear write must leave it alone; a controller that ignored the mask or cleared the whole register would show it. A nonmaskable edge during a user handler must be acknowledged at once and replace the shadow copy. An edge-detect fault would instead show up as a flag re-set by a line held low.

// File: rtl/intr_pkg.sv
package intr_pkg;

    // width of the internal interrupt-number field
    localparam int NUM_W = 5;

    // arbitration outcome carried from the priority pick to the registers
    typedef struct packed {
        logic             valid;
        logic             is_nmi;
        logic [NUM_W-1:0] num;
    } irq_sel_t;

    // vector address: base plus twice the interrupt number
    function automatic int vec_addr(input int base, input int num);
        return base + 2 * num;
    endfunction

endpackage

// File: rtl/intr_edge_sync.sv
module intr_edge_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] line_n,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] s1_q, s2_q, s3_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '1;
            s2_q <= '1;
            s3_q <= '1;
        end else begin
            s1_q <= line_n;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    // high-to-low transition seen on the synchronized copy
    assign fall_o = s3_q & ~s2_q;

    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (fall_o != '0) |=> ((fall_o & $past(fall_o)) == '0)); // R2

endmodule

// File: rtl/intr_arbiter.sv
module intr_arbiter
    import intr_pkg::*;
#(
    parameter int N_USER   = 4,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 0,
    parameter int NMI_NUM  = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_USER-1:0] fall_user,
    input  logic              fall_nmi,
    input  logic              mask_we,
    input  logic [N_USER-1:0] mask_wdata,
    input  logic              flag_clr_we,
    input  logic [N_USER-1:0] flag_clr_data,
    input  logic              blk_set,
    input  logic              blk_clr,
    input  logic              ret,
    output logic              save_en,
    output logic              ack_o,
    output logic [VEC_W-1:0]  vec_o,
    output logic [N_USER-1:0] flag_o,
    output logic [N_USER-1:0] mask_o,
    output logic              blk_o
);
    logic [N_USER-1:0] flag_q, mask_q, grant_oh, flag_nx, clr_bits;
    logic              blk_q, nmi_pend_q, ack_q, ack_nmi_q;
    logic [VEC_W-1:0]  vec_q;
    irq_sel_t          sel;

    // priority pick: NMI first, then lowest index among enabled users
    always_comb begin
        sel      = '0;
        grant_oh = '0;
        if (nmi_pend_q) begin
            sel.valid  = 1'b1;
            sel.is_nmi = 1'b1;
            sel.num    = NUM_W'(NMI_NUM);
        end else if (!blk_q) begin
            for (int i = N_USER - 1; i >= 0; i--) begin
                if (flag_q[i] && mask_q[i]) begin
                    grant_oh    = '0;
                    grant_oh[i] = 1'b1;
                    sel.valid   = 1'b1;
                    sel.num     = NUM_W'(i + 1);
                end
            end
        end
    end

    assign clr_bits = flag_clr_we ? flag_clr_data : '0;
    // a new edge in the same cycle as a clear keeps the flag set
    assign flag_nx  = (flag_q & ~clr_bits & ~grant_oh) | fall_user;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q     <= '0;
            mask_q     <= '0;
            blk_q      <= 1'b1;
            nmi_pend_q <= 1'b0;
            ack_q      <= 1'b0;
            ack_nmi_q  <= 1'b0;
            vec_q      <= '0;
        end else begin
            flag_q     <= flag_nx;
            nmi_pend_q <= (nmi_pend_q & ~(sel.valid & sel.is_nmi)) | fall_nmi;
            ack_q      <= sel.valid;
            ack_nmi_q  <= sel.valid & sel.is_nmi;
            if (sel.valid)
                vec_q <= VEC_W'(vec_addr(VEC_BASE, int'(sel.num)));
            if (mask_we)
                mask_q <= mask_wdata;
            if (sel.valid)
                blk_q <= 1'b1;
            else if (ret)
                blk_q <= 1'b0;
            else if (blk_set)
                blk_q <= 1'b1;
            else if (blk_clr)
                blk_q <= 1'b0;
        end
    end

    assign save_en = sel.valid;
    assign ack_o   = ack_q;
    assign vec_o   = vec_q;
    assign flag_o  = flag_q;
    assign mask_o  = mask_q;
    assign blk_o   = blk_q;

    AST_BLOCK_ON_ENTRY: assert property (@(posedge clk) disable iff (rst)
        ack_q |-> blk_q); // R6

    AST_USER_ENABLED: assert property (@(posedge clk) disable iff (rst)
        (ack_q && !ack_nmi_q) |-> $past(!blk_q && ((flag_q & mask_q) != '0))); // R3

    AST_NMI_FIRST: assert property (@(posedge clk) disable iff (rst)
        ack_q |-> (ack_nmi_q == $past(nmi_pend_q))); // R9

    AST_BLOCKED_IDLE: assert property (@(posedge clk) disable iff (rst)
        ($past(blk_q) && !$past(nmi_pend_q)) |-> !ack_q); // R3

endmodule

// File: rtl/intr_shadow.sv
module intr_shadow #(
    parameter int CTX_REGS = 11,
    parameter int CTX_W    = 16,
    localparam int CTX_BITS = CTX_REGS * CTX_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                save_en,
    input  logic                ret,
    input  logic [CTX_BITS-1:0] ctx_in,
    output logic [CTX_BITS-1:0] ctx_out,
    output logic                restore_o
);
    logic [CTX_W-1:0] shadow_q [CTX_REGS];
    logic             restore_q;

    // one storage slot per context register; a new save overwrites the old
    for (genvar g = 0; g < CTX_REGS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                shadow_q[g] <= '0;
            else if (save_en)
                shadow_q[g] <= ctx_in[g*CTX_W +: CTX_W];
        end
        assign ctx_out[g*CTX_W +: CTX_W] = shadow_q[g];
    end

    always_ff @(posedge clk) begin
        if (rst)
            restore_q <= 1'b0;
        else
            restore_q <= ret;
    end

    assign restore_o = restore_q;

    AST_SAVE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        save_en |=> (ctx_out == $past(ctx_in))); // R7

    AST_RESTORE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (restore_q && !$past(save_en)) |-> $stable(ctx_out)); // R8

endmodule

// File: rtl/intr_prio_ctl.sv
module intr_prio_ctl
    import intr_pkg::*;
#(
    parameter int N_USER   = 4,
    parameter int CTX_REGS = 11,
    parameter int CTX_W    = 16,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 0,
    parameter int NMI_NUM  = 18
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N_USER-1:0]         irq_n,
    input  logic                      nmi_n,
    input  logic                      mask_we,
    input  logic [N_USER-1:0]         mask_wdata,
    input  logic                      flag_clr_we,
    input  logic [N_USER-1:0]         flag_clr_data,
    input  logic                      blk_set,
    input  logic                      blk_clr,
    input  logic                      irq_ret,
    input  logic [CTX_REGS*CTX_W-1:0] ctx_in,
    output logic                      irq_ack,
    output logic [VEC_W-1:0]          irq_vector,
    output logic [CTX_REGS*CTX_W-1:0] ctx_out,
    output logic                      ctx_restore,
    output logic [N_USER-1:0]         flag_out,
    output logic [N_USER-1:0]         mask_out,
    output logic                      blk_out
);
    logic [N_USER-1:0] fall_user;
    logic [0:0]        fall_nmi;
    logic              save_en;

    intr_edge_sync #(.W(N_USER)) u_sync_user (
        .clk    (clk),
        .rst    (rst),
        .line_n (irq_n),
        .fall_o (fall_user)
    );

    intr_edge_sync #(.W(1)) u_sync_nmi (
        .clk    (clk),
        .rst    (rst),
        .line_n (nmi_n),
        .fall_o (fall_nmi)
    );

    intr_arbiter #(
        .N_USER   (N_USER),
        .VEC_W    (VEC_W),
        .VEC_BASE (VEC_BASE),
        .NMI_NUM  (NMI_NUM)
    ) u_arb (
        .clk           (clk),
        .rst           (rst),
        .fall_user     (fall_user),
        .fall_nmi      (fall_nmi[0]),
        .mask_we       (mask_we),
        .mask_wdata    (mask_wdata),
        .flag_clr_we   (flag_clr_we),
        .flag_clr_data (flag_clr_data),
        .blk_set       (blk_set),
        .blk_clr       (blk_clr),
        .ret           (irq_ret),
        .save_en       (save_en),
        .ack_o         (irq_ack),
        .vec_o         (irq_vector),
        .flag_o        (flag_out),
        .mask_o        (mask_out),
        .blk_o         (blk_out)
    );

    intr_shadow #(
        .CTX_REGS (CTX_REGS),
        .CTX_W    (CTX_W)
    ) u_shadow (
        .clk       (clk),
        .rst       (rst),
        .save_en   (save_en),
        .ret       (irq_ret),
        .ctx_in    (ctx_in),
        .ctx_out   (ctx_out),
        .restore_o (ctx_restore)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!irq_ack && !ctx_restore)); // R1

endmodule

// File: tb/intr_prio_ctl_tb.sv
module intr_prio_ctl_tb;
    localparam int N_USER   = 4;
    localparam int CTX_REGS = 11;
    localparam int CTX_W    = 16;
    localparam int VEC_W    = 8;
    localparam int VEC_BASE = 0;
    localparam int NMI_NUM  = 18;
    localparam int CB       = CTX_REGS * CTX_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [N_USER-1:0] irq_n = '1;
    logic              nmi_n = 1'b1;
    logic              mask_we = 1'b0, flag_clr_we = 1'b0;
    logic [N_USER-1:0] mask_wdata = '0, flag_clr_data = '0;
    logic              blk_set = 1'b0, blk_clr = 1'b0, irq_ret = 1'b0;
    logic [CB-1:0]     ctx_in = '0;
    logic              irq_ack, ctx_restore, blk_out;
    logic [VEC_W-1:0]  irq_vector;
    logic [CB-1:0]     ctx_out;
    logic [N_USER-1:0] flag_out, mask_out;

    int checks = 0, failures = 0, ack_cnt = 0, pushed = 0;
    bit done = 1'b0;
    int exp_q[$];

    always #10 clk = ~clk;

    intr_prio_ctl #(
        .N_USER(N_USER), .CTX_REGS(CTX_REGS), .CTX_W(CTX_W),
        .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .NMI_NUM(NMI_NUM)
    ) u_dut (
        .clk(clk), .rst(rst), .irq_n(irq_n), .nmi_n(nmi_n),
        .mask_we(mask_we), .mask_wdata(mask_wdata),
        .flag_clr_we(flag_clr_we), .flag_clr_data(flag_clr_data),
        .blk_set(blk_set), .blk_clr(blk_clr), .irq_ret(irq_ret),
        .ctx_in(ctx_in), .irq_ack(irq_ack), .irq_vector(irq_vector),
        .ctx_out(ctx_out), .ctx_restore(ctx_restore),
        .flag_out(flag_out), .mask_out(mask_out), .blk_out(blk_out)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int vec_of(input int n);
        return VEC_BASE + 2 * n;
    endfunction

    function automatic logic [CB-1:0] pat(input logic [15:0] seed);
        logic [CB-1:0] v = '0;
        for (int r = 0; r < CTX_REGS; r++) v[r*CTX_W +: CTX_W] = CTX_W'(seed + 16'(r));
        return v;
    endfunction

    // scoreboard driver side
    task automatic push_exp(input int v);
        exp_q.push_back(v);
        pushed++;
    endtask

    // scoreboard monitor side
    always @(negedge clk) begin
        if (!rst && irq_ack) begin
            ack_cnt++;
            if (exp_q.size() == 0)
                chk(1'b0, "R6 unexpected ack", longint'(irq_vector), 0);
            else begin
                int e;
                e = exp_q.pop_front();
                chk(irq_vector == VEC_W'(e), "R6/R9 vector order", longint'(irq_vector), longint'(e));
                chk(blk_out == 1'b1, "R6 block set on entry", longint'(blk_out), 1);
            end
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_line(input int idx);
        @(negedge clk); irq_n[idx] = 1'b0;
        cycles(5);
        irq_n[idx] = 1'b1;
    endtask

    task automatic pulse_nmi();
        @(negedge clk); nmi_n = 1'b0;
        cycles(5);
        nmi_n = 1'b1;
    endtask

    task automatic wr_mask(input logic [N_USER-1:0] m);
        @(negedge clk); mask_we = 1'b1; mask_wdata = m;
        @(negedge clk); mask_we = 1'b0;
    endtask

    task automatic wr_clr(input logic [N_USER-1:0] m);
        @(negedge clk); flag_clr_we = 1'b1; flag_clr_data = m;
        @(negedge clk); flag_clr_we = 1'b0;
    endtask

    task automatic blk(input bit set);
        @(negedge clk); if (set) blk_set = 1'b1; else blk_clr = 1'b1;
        @(negedge clk); blk_set = 1'b0; blk_clr = 1'b0;
    endtask

    task automatic wait_acks(input int target);
        int t = 0;
        while (ack_cnt < target && t < 300) begin
            @(negedge clk);
            t++;
        end
        chk(ack_cnt >= target, "R6 ack arrived", longint'(ack_cnt), longint'(target));
    endtask

    task automatic do_ret(input logic [CB-1:0] saved);
        @(negedge clk); irq_ret = 1'b1;
        @(negedge clk); irq_ret = 1'b0;
        chk(ctx_restore == 1'b1, "R8 restore pulse", longint'(ctx_restore), 1);
        chk(ctx_out == saved, "R8 restored context", longint'(ctx_out[63:0]), longint'(saved[63:0]));
        chk(blk_out == 1'b0, "R8 block cleared on return", longint'(blk_out), 0);
        @(negedge clk);
        chk(ctx_restore == 1'b0, "R8 restore single cycle", longint'(ctx_restore), 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        cycles(3);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(irq_ack == 1'b0, "R1 ack after reset", longint'(irq_ack), 0);
        chk(irq_vector == '0, "R1 vector after reset", longint'(irq_vector), 0);
        chk(flag_out == '0, "R1 flags after reset", longint'(flag_out), 0);
        chk(mask_out == '0, "R1 mask after reset", longint'(mask_out), 0);
        chk(blk_out == 1'b1, "R1 block after reset", longint'(blk_out), 1);
        chk(ctx_restore == 1'b0, "R1 restore after reset", longint'(ctx_restore), 0);

        // single request, context save, hold-low seen once
        ctx_in = pat(16'h1000);
        wr_mask(4'hF);
        blk(1'b0);
        push_exp(vec_of(3));
        fork
            pulse_line(2);
            wait_acks(1);
        join
        ctx_in = pat(16'h2000);
        @(negedge clk);
        chk(ctx_out == pat(16'h1000), "R7 saved context", longint'(ctx_out[63:0]), longint'(pat(16'h1000)));
        chk(flag_out == 4'b0000, "R6 flag cleared on serve", longint'(flag_out), 0);
        cycles(10);
        chk(flag_out == 4'b0000, "R2 held-low line sets once", longint'(flag_out), 0);
        do_ret(pat(16'h1000));

        // blocked requests held, then priority order
        blk(1'b1);
        pulse_line(3);
        pulse_line(1);
        cycles(6);
        chk(flag_out == 4'b1010, "R2/R3 flags pending while blocked", longint'(flag_out), 4'b1010);
        chk(ack_cnt == 1, "R3 no ack while blocked", longint'(ack_cnt), 1);
        wr_clr(4'b0000);
        cycles(1);
        chk(flag_out == 4'b1010, "R5 zero clear bits no effect", longint'(flag_out), 4'b1010);
        push_exp(vec_of(2));
        push_exp(vec_of(4));
        blk(1'b0);
        wait_acks(2);
        cycles(1);
        chk(flag_out == 4'b1000, "R4 INT2 before INT4", longint'(flag_out), 4'b1000);
        do_ret(pat(16'h2000));
        wait_acks(3);
        cycles(1);
        chk(flag_out == 4'b0000, "R4 INT4 served last", longint'(flag_out), 0);
        do_ret(pat(16'h2000));

        // masked line stays pending, write-one-to-clear
        wr_mask(4'b1110);
        pulse_line(0);
        cycles(6);
        chk(flag_out == 4'b0001, "R3 masked flag pending", longint'(flag_out), 1);
        chk(ack_cnt == 3, "R3 masked line not acked", longint'(ack_cnt), 3);
        wr_clr(4'b0001);
        chk(flag_out == 4'b0000, "R5 flag cleared by write", longint'(flag_out), 0);
        wr_mask(4'hF);

        // nonmaskable entry during a user handler overwrites shadow
        ctx_in = pat(16'h3000);
        push_exp(vec_of(1));
        pulse_line(0);
        wait_acks(4);
        ctx_in = pat(16'h4000);
        push_exp(vec_of(NMI_NUM));
        pulse_nmi();
        wait_acks(5);
        @(negedge clk);
        chk(ctx_out == pat(16'h4000), "R10 shadow overwritten", longint'(ctx_out[63:0]), longint'(pat(16'h4000)));
        do_ret(pat(16'h4000));

        // nonmaskable with everything masked and blocked
        wr_mask(4'h0);
        blk(1'b1);
        push_exp(vec_of(NMI_NUM));
        pulse_nmi();
        wait_acks(6);
        do_ret(pat(16'h4000));

        // nonmaskable outranks a pending user flag
        wr_mask(4'hF);
        blk(1'b1);
        pulse_line(0);
        cycles(6);
        push_exp(vec_of(NMI_NUM));
        push_exp(vec_of(1));
        pulse_nmi();
        wait_acks(7);
        cycles(1);
        chk(flag_out == 4'b0001, "R9 nmi served ahead of INT1", longint'(flag_out), 1);
        @(negedge clk); irq_ret = 1'b1;
        @(negedge clk); irq_ret = 1'b0;
        wait_acks(8);
        cycles(5);

        chk(exp_q.size() == 0, "R6 all expected acks seen", longint'(exp_q.size()), 0);
        chk(ack_cnt == pushed, "R6 ack count", longint'(ack_cnt), longint'(pushed));
        finish_run();
    end

endmodule